// File: doc/BRIEF.md
# Secure Configuration Register Bank with Sticky Lock

This block is a small bank of 32-bit configuration registers on a simple single-cycle peripheral bus. Every request carries a security attribute. The bank screens each request before it can read or change anything. Transfers that are not full, aligned words are refused with a bus error. Non-secure requests to the bank's registers are turned away with a one-cycle illegal-access event and no error.

A control register at offset 0x000 holds a lock bit. Software can set the bit but cannot clear it. While the bit is set, every register in the bank keeps its value and writes to it are dropped silently. The lock falls back to 0 only on a reset of the bank or when a wakeup-from-standby strobe arrives. A global security-enable input decides whether the control register can be used at all. The configuration registers appear on output ports for the logic that consumes them.

Top module: `secure_cfg_bank`

## Requirements
- R1: A synchronous active-high reset clears the lock bit, all configuration registers, `rsp_valid`, `rsp_error` and `illegal_evt`.
- R2: A request sampled with `req_valid` high at a clock edge is answered at that same edge: `rsp_valid` is high for exactly one cycle, carrying `rsp_rdata`, `rsp_error` and `illegal_evt`. With no request, `rsp_valid` is low.
- R3: Only word transfers are accepted (`req_size` 2'b10 with `req_addr[1:0]` = 0). Size codes 2'b00 (byte), 2'b01 (halfword) and 2'b11, and misaligned words, all raise `rsp_error`, write nothing and read zero. They raise no illegal-access event.
- R4: A non-secure word access (`req_secure` = 0) to any register of the bank (offsets 0x000, 0x004, 0x008) is refused: a write changes nothing, a read returns zero, `illegal_evt` pulses for the one response cycle, and `rsp_error` stays low.
- R5: The control register sits at offset 0x000, and its bit 0 is the lock. Writing 1 to bit 0 sets the lock, and writing 0 to it has no effect. Bits 31:1 always read zero and ignore writes.
- R6: While `sec_enable` is 0, writes to the control register are ignored and reads of it return zero. The lock can only become set while `sec_enable` is 1.
- R7: While the lock is set, secure word writes to the configuration registers complete without a bus error but leave the stored values unchanged.
- R8: A one-cycle high on `wake_standby` clears the lock at the next edge and keeps the configuration values. If a wakeup and a lock-setting write arrive at the same edge, the wakeup wins.
- R9: When unlocked, a secure word write to offset 0x004 or 0x008 stores the data in configuration register 0 or 1. Register k appears on `cfg_o[32*k +: 32]` and reads back at its offset.
- R10: Word accesses to offsets outside the bank read zero, write nothing, and raise neither a bus error nor an illegal-access event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_enable | input | 1 | Global security enable; the control register is usable only when 1 |
| wake_standby | input | 1 | Wakeup-from-standby strobe that releases the lock |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset of the access |
| req_size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word, 11 invalid |
| req_secure | input | 1 | 1 = secure access |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W (32) | Read data, zero for refused or write requests |
| rsp_error | output | 1 | Bus error for a refused transfer size or alignment |
| illegal_evt | output | 1 | One-cycle pulse on a non-secure access to the bank |
| lock_o | output | 1 | Current lock state |
| cfg_o | output | NUM_CFG*DATA_W (64) | Configuration registers, register k at bits 32k+31:32k |

## Verification
A bad lock state reaches `lock_o` at the edge after the write or wakeup that caused it. It also shows up on the next secure read of offset 0x000, and as a configuration write that lands or fails against the rule. A mis-screened request shows on `rsp_error`, `illegal_evt` or `rsp_rdata` in the single response cycle, and a wrongly accepted write changes `cfg_o` at that same edge. Every fault therefore becomes visible within one cycle of the access that provokes it. The directed scenarios read back or observe the outputs right after each such access.

// File: rtl/secbank_pkg.sv
package secbank_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic size_bad;
    logic hit_ctrl;
    logic hit_cfg;
    logic sec_fault;
  } verdict_t;

endpackage

// File: rtl/secbank_access_filter.sv
module secbank_access_filter
  import secbank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_CFG = 2
) (
  input  logic               valid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  input  logic               secure,
  output verdict_t           verdict,
  output logic [NUM_CFG-1:0] cfg_sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  logic             size_ok;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign size_ok  = (xfer_size_e'(size) == SZ_WORD) && aligned;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_sel
    assign cfg_sel[i] = valid && size_ok && (word_idx == IDX_W'(i + 1));
  end

  always_comb begin
    verdict.size_bad  = valid && !size_ok;
    verdict.hit_ctrl  = valid && size_ok && (word_idx == '0);
    verdict.hit_cfg   = |cfg_sel;
    verdict.sec_fault = (verdict.hit_ctrl || verdict.hit_cfg) && !secure;
  end
endmodule

// File: rtl/secbank_lock_ctrl.sv
module secbank_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wake,
  input  logic set_req,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (rst)          lock_q <= 1'b0;
    else if (wake)    lock_q <= 1'b0;
    else if (set_req) lock_q <= 1'b1;
  end
endmodule

// File: rtl/secbank_cfg_regs.sv
module secbank_cfg_regs #(
  parameter int unsigned NUM_CFG = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CFG-1:0]        wr_en,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
    logic [DATA_W-1:0] value_q;
    always_ff @(posedge clk) begin
      if (rst)           value_q <= '0;
      else if (wr_en[i]) value_q <= wdata;
    end
    assign cfg_flat[i*DATA_W +: DATA_W] = value_q;
  end
endmodule

// File: rtl/secure_cfg_bank.sv
module secure_cfg_bank
  import secbank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_CFG = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sec_enable,
  input  logic                      wake_standby,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [1:0]                req_size,
  input  logic                      req_secure,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_error,
  output logic                      illegal_evt,
  output logic                      lock_o,
  output logic [NUM_CFG*DATA_W-1:0] cfg_o
);
  verdict_t           verdict;
  logic [NUM_CFG-1:0] cfg_sel;
  logic [NUM_CFG-1:0] cfg_wr;
  logic               lock_q;
  logic               ctrl_wr_ok;
  logic               lock_set_req;
  logic               access_ok;
  logic [DATA_W-1:0]  rd_word;

  secbank_access_filter #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) u_filter (
    .valid   (req_valid),
    .addr    (req_addr),
    .size    (req_size),
    .secure  (req_secure),
    .verdict (verdict),
    .cfg_sel (cfg_sel)
  );

  assign access_ok    = !verdict.sec_fault;
  assign ctrl_wr_ok   = req_write && verdict.hit_ctrl && access_ok && sec_enable;
  assign lock_set_req = ctrl_wr_ok && req_wdata[0];

  secbank_lock_ctrl u_lock (
    .clk     (clk),
    .rst     (rst),
    .wake    (wake_standby),
    .set_req (lock_set_req),
    .lock_q  (lock_q)
  );

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_wr
    assign cfg_wr[i] = req_write && cfg_sel[i] && access_ok && !lock_q;
  end

  secbank_cfg_regs #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .wdata    (req_wdata),
    .cfg_flat (cfg_o)
  );

  always_comb begin
    rd_word = '0;
    if (!req_write && access_ok) begin
      if (verdict.hit_ctrl && sec_enable) rd_word = {{(DATA_W-1){1'b0}}, lock_q};
      for (int i = 0; i < NUM_CFG; i++) begin
        if (cfg_sel[i]) rd_word = cfg_o[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_error   <= 1'b0;
      illegal_evt <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= rd_word;
      rsp_error   <= verdict.size_bad;
      illegal_evt <= verdict.sec_fault;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/secbank_checker.sv
module secbank_checker #(
  parameter int unsigned CFG_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_enable,
  input logic             wake_standby,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_error,
  input logic             illegal_evt,
  input logic             lock_o,
  input logic [CFG_W-1:0] cfg_o
);
  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid)); // R2
  AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_ERR_NOT_EVT: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> !illegal_evt); // R3
  AST_EVT_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    illegal_evt |-> rsp_valid); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lock_o && !wake_standby) |=> lock_o); // R5
  AST_LOCK_NEEDS_SE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(sec_enable)); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> $stable(cfg_o)); // R7
  AST_WAKE_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    wake_standby |=> !lock_o); // R8
endmodule

bind secure_cfg_bank secbank_checker #(.CFG_W(NUM_CFG*DATA_W)) u_checker (
  .clk          (clk),
  .rst          (rst),
  .sec_enable   (sec_enable),
  .wake_standby (wake_standby),
  .req_valid    (req_valid),
  .rsp_valid    (rsp_valid),
  .rsp_error    (rsp_error),
  .illegal_evt  (illegal_evt),
  .lock_o       (lock_o),
  .cfg_o        (cfg_o)
);

// File: tb/secure_cfg_bank_test.sv
`timescale 1ns/1ps
module secure_cfg_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_enable = 1'b1;
  logic        wake_standby = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic        req_secure = 1'b1;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_error;
  logic        illegal_evt;
  logic        lock_o;
  logic [63:0] cfg_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got_data;
  logic        got_err;
  logic        got_evt;
  logic        got_vld;

  always #5 clk = ~clk;

  secure_cfg_bank uut (
    .clk(clk), .rst(rst), .sec_enable(sec_enable), .wake_standby(wake_standby),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_secure(req_secure), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
    .illegal_evt(illegal_evt), .lock_o(lock_o), .cfg_o(cfg_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] addr, input logic [1:0] sz,
                        input logic sec, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr;
    req_size = sz; req_secure = sec; req_wdata = data;
    @(negedge clk);
    got_vld = rsp_valid; got_data = rsp_rdata; got_err = rsp_error; got_evt = illegal_evt;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 lock", lock_o, 0);
    check("R1 cfg", cfg_o, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 evt/err", {illegal_evt, rsp_error}, 0);
    access(1'b0, 12'h000, 2'b10, 1'b1, 0);
    check("R1 ctrl read", got_data, 0);
  endtask

  task automatic t_write_read();
    access(1'b1, 12'h004, 2'b10, 1'b1, 32'hA5A5_0001);
    check("R2 rsp_valid", got_vld, 1);
    check("R9 write no err", {got_err, got_evt}, 0);
    access(1'b1, 12'h008, 2'b10, 1'b1, 32'h1234_5678);
    check("R9 cfg_o", cfg_o, 64'h1234_5678_A5A5_0001);
    access(1'b0, 12'h004, 2'b10, 1'b1, 0);
    check("R9 read cfg0", got_data, 32'hA5A5_0001);
    access(1'b0, 12'h008, 2'b10, 1'b1, 0);
    check("R9 read cfg1", got_data, 32'h1234_5678);
    @(negedge clk);
    check("R2 idle no rsp", rsp_valid, 0);
  endtask

  task automatic t_size();
    access(1'b1, 12'h004, 2'b00, 1'b1, 32'hDEAD_BEEF);
    check("R3 byte err", {got_err, got_evt}, 2'b10);
    check("R3 byte no write", cfg_o[31:0], 32'hA5A5_0001);
    access(1'b0, 12'h008, 2'b01, 1'b1, 0);
    check("R3 half err+zero", {got_err, got_data}, {1'b1, 32'h0});
    access(1'b1, 12'h005, 2'b10, 1'b1, 32'hDEAD_BEEF);
    check("R3 misaligned err", got_err, 1);
    check("R3 misaligned no write", cfg_o, 64'h1234_5678_A5A5_0001);
    access(1'b0, 12'h004, 2'b11, 1'b1, 0);
    check("R3 code 11 err", {got_err, got_data}, {1'b1, 32'h0});
  endtask

  task automatic t_nonsecure();
    access(1'b1, 12'h008, 2'b10, 1'b0, 32'hFFFF_0000);
    check("R4 ns write evt no err", {got_evt, got_err}, 2'b10);
    check("R4 ns write dropped", cfg_o[63:32], 32'h1234_5678);
    access(1'b0, 12'h004, 2'b10, 1'b0, 0);
    check("R4 ns read zero", {got_evt, got_data}, {1'b1, 32'h0});
    @(negedge clk);
    check("R4 evt one cycle", illegal_evt, 0);
    access(1'b1, 12'h000, 2'b10, 1'b0, 32'h1);
    check("R4 ns ctrl no lock", {got_evt, lock_o}, 2'b10);
  endtask

  task automatic t_unmapped();
    access(1'b0, 12'h00C, 2'b10, 1'b1, 0);
    check("R10 read zero", {got_err, got_evt, got_data}, 34'h0);
    access(1'b1, 12'h010, 2'b10, 1'b0, 32'h5555_5555);
    check("R10 write quiet", {got_err, got_evt}, 0);
    check("R10 no change", cfg_o, 64'h1234_5678_A5A5_0001);
  endtask

  task automatic t_secen_off();
    sec_enable = 1'b0;
    access(1'b1, 12'h000, 2'b10, 1'b1, 32'h1);
    check("R6 no lock when SE=0", lock_o, 0);
    access(1'b0, 12'h000, 2'b10, 1'b1, 0);
    check("R6 read zero", got_data, 0);
    sec_enable = 1'b1;
  endtask

  task automatic t_lock();
    access(1'b1, 12'h000, 2'b10, 1'b1, 32'hFFFF_FFFE);
    check("R5 bit0=0 no lock", lock_o, 0);
    access(1'b1, 12'h000, 2'b10, 1'b1, 32'hFFFF_FFFF);
    check("R5 lock set", lock_o, 1);
    access(1'b0, 12'h000, 2'b10, 1'b1, 0);
    check("R5 reserved read zero", got_data, 32'h1);
    access(1'b1, 12'h000, 2'b10, 1'b1, 32'h0);
    check("R5 write 0 keeps lock", lock_o, 1);
    access(1'b1, 12'h004, 2'b10, 1'b1, 32'h0BAD_0BAD);
    check("R7 blocked no err", {got_err, got_evt}, 0);
    check("R7 cfg kept", cfg_o, 64'h1234_5678_A5A5_0001);
    access(1'b0, 12'h004, 2'b10, 1'b1, 0);
    check("R7 readback old", got_data, 32'hA5A5_0001);
    sec_enable = 1'b0;
    access(1'b0, 12'h000, 2'b10, 1'b1, 0);
    check("R6 locked SE=0 reads zero", got_data, 0);
    sec_enable = 1'b1;
  endtask

  task automatic t_wake();
    @(negedge clk); wake_standby = 1'b1;
    @(negedge clk); wake_standby = 1'b0;
    check("R8 wake clears lock", lock_o, 0);
    check("R8 cfg kept", cfg_o, 64'h1234_5678_A5A5_0001);
    access(1'b1, 12'h004, 2'b10, 1'b1, 32'h0000_00C3);
    check("R8 writable again", cfg_o[31:0], 32'h0000_00C3);
    @(negedge clk);
    wake_standby = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h000;
    req_size = 2'b10; req_secure = 1'b1; req_wdata = 32'h1;
    @(negedge clk);
    wake_standby = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    check("R8 wake beats set", lock_o, 0);
    access(1'b1, 12'h000, 2'b10, 1'b1, 32'h1);
    check("R5 relock", lock_o, 1);
    do_reset();
    check("R1 reset unlocks", lock_o, 0);
    check("R1 reset clears cfg", cfg_o, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_write_read();
    t_size();
    t_nonsecure();
    t_unmapped();
    t_secen_off();
    t_lock();
    t_wake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule